// File: doc/BRIEF.md
# Trace Stream Program Counter Rebuilder

This block takes a stream of 36-bit trace words produced by a processor core and works out which instruction address each word belongs to. Only words that report a branch carry an address. For every other word the address is inferred. After a result word the tracked address moves forward by the length of the instruction at that address. An address (memory access) word leaves the tracked address where it is. When the interrupt-active flag turns on, the tracked address jumps to the handler entry.

The block learns instruction lengths through a combinational lookup port. It drives the tracked address out on that port. In the same cycle an external instruction table answers with a found bit and the two lowest opcode bits. Each accepted word produces one output record with these fields: address, payload, kind, interrupt flag, an address-known flag and a missing-instruction flag. The record stays in an output register until the consumer takes it. After reset, or after a lookup that finds no instruction, the block has lost sync. Its records then report the address as unknown until a branch word or an interrupt entry restores sync.

Top module: `trace_pc_rebuild`

## Requirements
- R1: The record kind is 2 (branch) when word bit 32 is set, whether or not bit 33 is also set. It is 1 (address) when only bit 33 is set and 0 (result) otherwise. The record payload equals word bits 31:0, and the record interrupt flag equals word bit 35. Bit 34 has no effect on any output.
- R2: A branch word sets the tracked address to its payload. The next record carries that address with the address-known flag set.
- R3: If word bit 35 is set and was clear on the previous accepted word, the record carries address IRQ_VECTOR (default 0x10) with the address-known flag set. The previous-flag state is cleared by reset.
- R4: After a result word at a known address where the lookup finds an instruction, the tracked address advances by 4 when the lookup's two low opcode bits are 2'b11, and by 2 otherwise.
- R5: After an address word that is not a branch, the next word keeps the same tracked address.
- R6: After reset, records report the address as unknown (address-known = 0) until the first branch word or interrupt entry.
- R7: When the address is known and the lookup reports no instruction, the record sets the missing flag, and the address becomes unknown for the following words. A branch word in that position still restores sync. The missing flag is never set when the address is unknown.
- R8: The lookup address output shows, combinationally, the address of the word now offered at the input, including the interrupt-entry override.
- R9: After reset, out_valid is 0 and in_ready is 1. in_ready equals the inverse of out_valid. An accepted word sets out_valid on the next edge. The record holds unchanged until out_ready is seen with out_valid, which clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trace word offered |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 36 | Trace word: payload 31:0, branch 32, address 33, interrupt 35 |
| lk_pc | output | 32 | Address presented to the instruction lookup |
| lk_found | input | 1 | Lookup found an instruction at lk_pc |
| lk_low | input | 2 | Two lowest opcode bits of that instruction |
| out_valid | output | 1 | Record pending |
| out_ready | input | 1 | Consumer takes the record |
| out_pc | output | 32 | Rebuilt address of the word |
| out_payload | output | 32 | Word payload |
| out_kind | output | 2 | 0 result, 1 address, 2 branch |
| out_irq | output | 1 | Interrupt-active flag of the word |
| out_pc_known | output | 1 | Address is in sync |
| out_missing | output | 1 | Lookup had no instruction at a known address |

## Verification
The bench builds the block with its default 32-bit payload and a handler entry of 0x10. It attaches a computed instruction table: an instruction exists below 0x200, and the opcode low bits of a few addresses in every 16-byte block mark compressed instructions. Branch targets are drawn from 0 to 0x3FE, so a long pseudo-random word stream repeatedly walks off the table, loses sync and regains it. Along the way it covers every combination of the branch, address, interrupt and spare bits, including interrupt entries made while out of sync. Between records the consumer holds back for varying numbers of cycles.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int PAYLOAD_W = 32;
    localparam int WORD_W    = 36;
    localparam int BIT_BR    = 32;
    localparam int BIT_AD    = 33;
    localparam int BIT_IRQ   = 35;

    typedef enum logic [1:0] {
        KIND_DATA   = 2'd0,
        KIND_ADDR   = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] pc;
        logic [PAYLOAD_W-1:0] payload;
        kind_e                kind;
        logic                 irq;
        logic                 pc_known;
        logic                 missing;
    } rec_t;
endpackage

// File: rtl/trace_word_decode.sv
module trace_word_decode
    import trace_pkg::*;
(
    input  logic [WORD_W-1:0]    word,
    output logic [PAYLOAD_W-1:0] payload,
    output kind_e                kind,
    output logic                 irq
);
    always_comb begin
        payload = word[PAYLOAD_W-1:0];
        irq     = word[BIT_IRQ];
        if (word[BIT_BR])
            kind = KIND_BRANCH;
        else if (word[BIT_AD])
            kind = KIND_ADDR;
        else
            kind = KIND_DATA;
    end
endmodule

// File: rtl/trace_pc_step.sv
module trace_pc_step
    import trace_pkg::*;
(
    input  logic [PAYLOAD_W-1:0] pc_cur,
    input  logic                 known_cur,
    input  kind_e                kind,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic                 found,
    input  logic [1:0]           low,
    output logic [PAYLOAD_W-1:0] pc_next,
    output logic                 known_next,
    output logic                 missing
);
    localparam logic [PAYLOAD_W-1:0] STEP_FULL = PAYLOAD_W'(4);
    localparam logic [PAYLOAD_W-1:0] STEP_HALF = PAYLOAD_W'(2);

    always_comb begin
        missing    = known_cur && !found;
        pc_next    = pc_cur;
        known_next = known_cur;
        if (kind == KIND_BRANCH) begin
            pc_next    = payload;
            known_next = 1'b1;
        end else if (missing) begin
            known_next = 1'b0;
        end else if (known_cur && kind == KIND_DATA) begin
            pc_next = pc_cur + ((low == 2'b11) ? STEP_FULL : STEP_HALF);
        end
    end
endmodule

// File: rtl/trace_pc_rebuild.sv
module trace_pc_rebuild
    import trace_pkg::*;
#(
    parameter logic [31:0] IRQ_VECTOR = 32'h0000_0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [35:0] in_word,
    output logic [31:0] lk_pc,
    input  logic        lk_found,
    input  logic [1:0]  lk_low,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_pc,
    output logic [31:0] out_payload,
    output logic [1:0]  out_kind,
    output logic        out_irq,
    output logic        out_pc_known,
    output logic        out_missing
);
    typedef struct packed {
        logic [PAYLOAD_W-1:0] pc;
        logic                 known;
        logic                 prev_irq;
        logic                 valid;
        rec_t                 rec;
    } state_t;

    state_t st_q, st_d;

    logic [PAYLOAD_W-1:0] dec_payload;
    kind_e                dec_kind;
    logic                 dec_irq;
    logic                 entry_d;
    logic [PAYLOAD_W-1:0] pc_cur_d;
    logic                 known_cur_d;
    logic [PAYLOAD_W-1:0] pc_next_d;
    logic                 known_next_d;
    logic                 missing_d;
    logic                 accept_d;

    trace_word_decode u_decode (
        .word    (in_word),
        .payload (dec_payload),
        .kind    (dec_kind),
        .irq     (dec_irq)
    );

    always_comb begin
        entry_d     = dec_irq && !st_q.prev_irq;
        pc_cur_d    = entry_d ? IRQ_VECTOR : st_q.pc;
        known_cur_d = entry_d || st_q.known;
    end

    trace_pc_step u_step (
        .pc_cur     (pc_cur_d),
        .known_cur  (known_cur_d),
        .kind       (dec_kind),
        .payload    (dec_payload),
        .found      (lk_found),
        .low        (lk_low),
        .pc_next    (pc_next_d),
        .known_next (known_next_d),
        .missing    (missing_d)
    );

    assign in_ready = !st_q.valid;
    assign accept_d = in_valid && in_ready;
    assign lk_pc    = pc_cur_d;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready)
            st_d.valid = 1'b0;
        if (accept_d) begin
            st_d.valid            = 1'b1;
            st_d.pc               = pc_next_d;
            st_d.known            = known_next_d;
            st_d.prev_irq         = dec_irq;
            st_d.rec.pc           = pc_cur_d;
            st_d.rec.payload      = dec_payload;
            st_d.rec.kind         = dec_kind;
            st_d.rec.irq          = dec_irq;
            st_d.rec.pc_known     = known_cur_d;
            st_d.rec.missing      = missing_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_pc       = st_q.rec.pc;
    assign out_payload  = st_q.rec.payload;
    assign out_kind     = st_q.rec.kind;
    assign out_irq      = st_q.rec.irq;
    assign out_pc_known = st_q.rec.pc_known;
    assign out_missing  = st_q.rec.missing;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_payload)
            && $stable(out_kind) && $stable(out_irq) && $stable(out_pc_known) && $stable(out_missing));

    // R9
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R2
    branch_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_d && dec_kind == KIND_BRANCH |=> st_q.known && st_q.pc == $past(dec_payload));

    // R3
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_d && dec_irq && !st_q.prev_irq |=> out_pc == IRQ_VECTOR && out_pc_known);

    // R7
    missing_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_missing |-> out_pc_known);

    // R1
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_kind != 2'd3);
endmodule

// File: tb/tb_trace_pc_rebuild.sv
`timescale 1ns/1ps
module tb_trace_pc_rebuild;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [35:0] in_word = '0;
    logic [31:0] lk_pc;
    logic        lk_found;
    logic [1:0]  lk_low;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_pc;
    logic [31:0] out_payload;
    logic [1:0]  out_kind;
    logic        out_irq;
    logic        out_pc_known;
    logic        out_missing;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic bit tab_found(input logic [31:0] a);
        return a < 32'h200;
    endfunction
    function automatic logic [1:0] tab_low(input logic [31:0] a);
        return (a[3:1] == 3'd5 || a[3:1] == 3'd2) ? 2'b01 : 2'b11;
    endfunction

    assign lk_found = tab_found(lk_pc);
    assign lk_low   = tab_low(lk_pc);

    trace_pc_rebuild dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .lk_pc(lk_pc), .lk_found(lk_found), .lk_low(lk_low),
        .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
        .out_payload(out_payload), .out_kind(out_kind), .out_irq(out_irq),
        .out_pc_known(out_pc_known), .out_missing(out_missing)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench model state
    logic [31:0] m_pc = '0;
    bit m_known = 0;
    bit m_prev = 0;
    string m_reason = "R6";

    task automatic send(input logic [35:0] w, input int hold);
        bit entry, kn, found, miss;
        logic [31:0] pcc;
        logic [1:0] low, kexp;
        string why;
        entry = w[35] && !m_prev;
        pcc   = entry ? 32'h10 : m_pc;
        kn    = entry || m_known;
        found = tab_found(pcc);
        low   = tab_low(pcc);
        miss  = kn && !found;
        kexp  = w[32] ? 2'd2 : (w[33] ? 2'd1 : 2'd0);
        why   = entry ? "R3" : m_reason;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #0.5;
        chk(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);
        if (kn) chk(lk_pc == pcc, "R8", 64'(lk_pc), 64'(pcc));
        @(negedge clk);
        in_valid = 1'b0;
        for (int h = 0; h <= hold; h++) begin
            if (h > 0) @(negedge clk);
            chk(out_valid == 1'b1 && in_ready == 1'b0, "R9", 64'({out_valid, in_ready}), 64'b10);
            chk(out_kind == kexp, "R1", 64'(out_kind), 64'(kexp));
            chk(out_payload == w[31:0] && out_irq == w[35], "R1",
                64'({out_irq, out_payload}), 64'({w[35], w[31:0]}));
            chk(out_pc_known == kn, m_known ? "R7" : (entry ? "R3" : "R6"), 64'(out_pc_known), 64'(kn));
            if (kn) chk(out_pc == pcc, why, 64'(out_pc), 64'(pcc));
            chk(out_missing == miss, "R7", 64'(out_missing), 64'(miss));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", 64'({out_valid, in_ready}), 64'b01);
        // model update
        m_prev = w[35];
        if (w[32]) begin
            m_pc = w[31:0]; m_known = 1; m_reason = "R2";
        end else if (miss) begin
            m_known = 0; m_pc = pcc; m_reason = "R7";
        end else if (kn && !w[33]) begin
            m_pc = pcc + ((low == 2'b11) ? 32'd4 : 32'd2); m_known = 1; m_reason = "R4";
        end else begin
            m_pc = pcc; m_known = kn; m_reason = w[33] ? "R5" : "R6";
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        bit irqf;
        irqf = 0;
        r = 32'h1234_5679;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state, R6 unknown after reset
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", 64'({out_valid, in_ready}), 64'b01);
        send({4'b0000, 32'hDEAD_0001}, 0);
        send({4'b0010, 32'h0000_0040}, 1);
        send({4'b0100, 32'h0000_0002}, 0);       // R1 spare bit 34 ignored
        send({4'b0011, 32'h0000_0100}, 2);       // R1 both bits: branch
        send({4'b0000, 32'h0000_0005}, 0);       // R4
        send({4'b0010, 32'h0000_0800}, 0);       // R5
        send({4'b0000, 32'h0000_0006}, 0);
        send({4'b1000, 32'h0000_0007}, 1);       // R3 entry
        send({4'b1000, 32'h0000_0008}, 0);
        send({4'b0001, 32'h0000_01FC}, 0);       // R2 near table end
        for (int k = 0; k < 6; k++) send({4'b0000, 32'(k)}, 0); // R7 walk off
        for (int i = 0; i < 1500; i++) begin
            logic [35:0] w;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            if (r[9:6] == 4'd0) irqf = !irqf;
            w[31:0] = r;
            w[32]   = (r[2:0] == 3'd0);
            w[33]   = (r[4:3] == 2'd0);
            w[34]   = r[10];
            w[35]   = irqf;
            if (w[32]) w[31:0] = {22'd0, r[25:17], 1'b0};
            send(w, i % 3);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule